// File: doc/BRIEF.md
# SIMT Branch Reconvergence Stack

This block tracks control flow for a single 32-lane warp whose lanes may disagree on a branch. It keeps the program counter of the instruction being issued, a mask of lanes that are still allowed to execute, and a small stack of saved (PC, mask) pairs. Every cycle the issue logic presents one decoded control operation for the instruction at `pc`, along with a per-lane predicate vector. The block answers combinationally with the PC and mask for the following instruction, and registers them at the clock edge.

A set-sync operation records where the divergent region will rejoin, together with the lanes that entered it. A branch on which the active lanes agree simply redirects the PC or falls through. A branch on which they disagree runs the taken lanes first and parks the remaining lanes, with their fall-through PC, on the stack. A sync-pop resumes the parked lanes or, once every path has finished, the rejoin point with the original mask. Lanes that exit are cleared from the mask and from every saved entry. Saved entries that end up with no lanes are skipped. When the last running lanes exit, the block pops the stack instead of leaving the warp with no lanes. Each warp in a core has its own instance.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset `pc` is RESET_PC (0), `activeMask` is all ones, both error flags are clear and the stack is empty.
- R2: Operation codes on `opKind` are 0 no-op, 1 set-sync, 2 branch, 3 sync-pop and 4 exit; codes 5 to 7 act as a no-op. A no-op advances the PC by PC_STEP (8). A cycle with `opValid` low holds both the PC and the mask. `nextPc` and `nextMask` show the outcome in the same cycle.
- R3: A set-sync pushes (`opTarget`, current mask) and advances the PC by PC_STEP. The mask does not change.
- R4: A branch with `predMask & activeMask` equal to `activeMask` goes to `opTarget`. A branch with `predMask & activeMask` equal to zero goes to PC+PC_STEP. Neither case changes the mask or pushes an entry.
- R5: A branch where only some active lanes have their predicate bit set goes to `opTarget` with the mask `predMask & activeMask`. It pushes (PC+PC_STEP, `activeMask & ~predMask`).
- R6: A sync-pop removes the top entry and continues at that entry's PC with its mask. Entries come back in last-in, first-out order.
- R7: When the entries being popped have a zero mask, they are discarded in the same operation, and the topmost entry with a nonzero mask is used.
- R8: An exit clears the lanes `predMask & activeMask` from the mask and from every stack entry. If lanes remain, the PC advances by PC_STEP.
- R9: When an exit would leave no lanes, the block pops as in R6 and R7. If no entry has any lanes, the mask becomes zero and the PC holds. From then on every operation is ignored.
- R10: A push when DEPTH (16) entries are held is dropped and sets `overflowErr`, which stays set until reset. A divergent branch at a full stack still continues with the taken mask at `opTarget`.
- R11: A sync-pop that finds no entry with a nonzero mask sets `underflowErr`, which stays set until reset. It empties the stack, advances the PC by PC_STEP and leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | An operation is issued this cycle |
| opKind | input | 3 | Operation code (see R2) |
| opTarget | input | PC_W | Branch target or rejoin PC |
| predMask | input | LANES | Per-lane predicate for branch and exit |
| pc | output | PC_W | PC of the instruction being issued |
| nextPc | output | PC_W | PC after this cycle's operation |
| activeMask | output | LANES | Lanes enabled for the current instruction |
| nextMask | output | LANES | Mask after this cycle's operation |
| overflowErr | output | 1 | Sticky push-at-full flag |
| underflowErr | output | 1 | Sticky pop-with-nothing flag |

## Verification
The hardest state to reach is a sync-pop or forced pop that meets a saved entry with no lanes left. Lanes only vanish from saved entries through exits, so the stimulus builds a two-level nest of divergent branches. It then retires lanes in stages until one inner rejoin entry is empty and must be skipped to reach an outer deferred entry. Overflow is reached by sixteen set-syncs in a row, followed by a divergent branch whose push must be dropped. A final pop then shows that the dropped entry never reached the stack.

// File: rtl/simt_pkg.sv
package simt_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_SSY  = 3'd1,
    OP_BRA  = 3'd2,
    OP_SPOP = 3'd3,
    OP_EXIT = 3'd4
  } opKind_e;

  typedef enum logic [1:0] {
    PC_HOLD,
    PC_SEQ,
    PC_TARGET,
    PC_POPPED
  } pcSel_e;

  typedef enum logic [1:0] {
    MK_KEEP,
    MK_TAKEN,
    MK_REMAIN,
    MK_POPPED
  } maskSel_e;

  typedef struct packed {
    logic     doPush;
    logic     pushDeferred;
    logic     doPop;
    logic     doClear;
    logic     setOvf;
    logic     setUnf;
    pcSel_e   pcSel;
    maskSel_e maskSel;
  } strobe_t;

endpackage

// File: rtl/simt_reconv_ctrl.sv
module simt_reconv_ctrl
  import simt_pkg::*;
(
  input  logic       opValid,
  input  logic [2:0] opKind,
  input  logic       running,
  input  logic       effNone,
  input  logic       effAll,
  input  logic       remainNone,
  input  logic       stackFull,
  input  logic       foundValid,
  output strobe_t    strobe
);

  always_comb begin
    strobe = '0;
    strobe.pcSel = PC_HOLD;
    strobe.maskSel = MK_KEEP;
    if (opValid && running) begin
      case (opKind)
        OP_SSY: begin
          strobe.pcSel = PC_SEQ;
          if (stackFull) strobe.setOvf = 1'b1;
          else           strobe.doPush = 1'b1;
        end
        OP_BRA: begin
          if (effNone) begin
            strobe.pcSel = PC_SEQ;
          end else if (effAll) begin
            strobe.pcSel = PC_TARGET;
          end else begin
            strobe.pcSel = PC_TARGET;
            strobe.maskSel = MK_TAKEN;
            strobe.pushDeferred = 1'b1;
            if (stackFull) strobe.setOvf = 1'b1;
            else           strobe.doPush = 1'b1;
          end
        end
        OP_SPOP: begin
          strobe.doPop = 1'b1;
          if (foundValid) begin
            strobe.pcSel = PC_POPPED;
            strobe.maskSel = MK_POPPED;
          end else begin
            strobe.setUnf = 1'b1;
            strobe.pcSel = PC_SEQ;
          end
        end
        OP_EXIT: begin
          strobe.doClear = 1'b1;
          if (!remainNone) begin
            strobe.maskSel = MK_REMAIN;
            strobe.pcSel = PC_SEQ;
          end else begin
            strobe.doPop = 1'b1;
            if (foundValid) begin
              strobe.pcSel = PC_POPPED;
              strobe.maskSel = MK_POPPED;
            end else begin
              strobe.maskSel = MK_REMAIN;
              strobe.pcSel = PC_HOLD;
            end
          end
        end
        default: strobe.pcSel = PC_SEQ;
      endcase
    end
  end

endmodule

// File: rtl/simt_reconv_dpath.sv
module simt_reconv_dpath
  import simt_pkg::*;
#(
  parameter int LANES    = 32,
  parameter int PC_W     = 32,
  parameter int DEPTH    = 16,
  parameter int PC_STEP  = 8,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic             exitNow,
  input  logic [PC_W-1:0]  opTarget,
  input  logic [LANES-1:0] predMask,
  output logic [PC_W-1:0]  pc,
  output logic [PC_W-1:0]  nextPc,
  output logic [LANES-1:0] activeMask,
  output logic [LANES-1:0] nextMask,
  output logic             overflowErr,
  output logic             underflowErr,
  output logic             running,
  output logic             effNone,
  output logic             effAll,
  output logic             remainNone,
  output logic             stackFull,
  output logic             foundValid
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  logic [PC_W-1:0]  pcQ;
  logic [LANES-1:0] maskQ;
  logic [CNT_W-1:0] depthQ;
  logic             ovfQ, unfQ;

  logic [PC_W-1:0]  stackPc   [DEPTH];
  logic [LANES-1:0] stackMask [DEPTH];

  logic [LANES-1:0] effMask, remainMask, clearVec, poppedMask, pushMask;
  logic [PC_W-1:0]  seqPc, poppedPc, pushPc;
  logic [CNT_W-1:0] foundIdx;

  assign effMask    = predMask & maskQ;
  assign remainMask = maskQ & ~predMask;
  assign seqPc      = pcQ + PC_W'(PC_STEP);
  assign clearVec   = exitNow ? effMask : '0;
  assign pushPc     = strobe.pushDeferred ? seqPc : opTarget;
  assign pushMask   = strobe.pushDeferred ? remainMask : maskQ;

  assign running    = (maskQ != '0);
  assign effNone    = (effMask == '0);
  assign effAll     = (effMask == maskQ);
  assign remainNone = (remainMask == '0);
  assign stackFull  = (depthQ == CNT_W'(DEPTH));

  // topmost live entry, seen with this cycle's exiting lanes removed
  always_comb begin
    foundValid = 1'b0;
    foundIdx   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CNT_W'(i) < depthQ && (stackMask[i] & ~clearVec) != '0) begin
        foundValid = 1'b1;
        foundIdx   = CNT_W'(i);
      end
    end
  end

  assign poppedPc   = stackPc[foundIdx[IDX_W-1:0]];
  assign poppedMask = stackMask[foundIdx[IDX_W-1:0]] & ~clearVec;

  always_comb begin
    case (strobe.pcSel)
      PC_SEQ:    nextPc = seqPc;
      PC_TARGET: nextPc = opTarget;
      PC_POPPED: nextPc = poppedPc;
      default:   nextPc = pcQ;
    endcase
    case (strobe.maskSel)
      MK_TAKEN:  nextMask = effMask;
      MK_REMAIN: nextMask = remainMask;
      MK_POPPED: nextMask = poppedMask;
      default:   nextMask = maskQ;
    endcase
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    logic [PC_W-1:0]  ePc;
    logic [LANES-1:0] eMask;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ePc   <= '0;
        eMask <= '0;
      end else if (strobe.doPush && depthQ == CNT_W'(g)) begin
        ePc   <= pushPc;
        eMask <= pushMask;
      end else if (strobe.doClear) begin
        eMask <= eMask & ~effMask;
      end
    end
    assign stackPc[g]   = ePc;
    assign stackMask[g] = eMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ    <= RESET_PC;
      maskQ  <= '1;
      depthQ <= '0;
      ovfQ   <= 1'b0;
      unfQ   <= 1'b0;
    end else begin
      pcQ   <= nextPc;
      maskQ <= nextMask;
      if (strobe.doPush)     depthQ <= depthQ + CNT_W'(1);
      else if (strobe.doPop) depthQ <= foundValid ? foundIdx : '0;
      if (strobe.setOvf) ovfQ <= 1'b1;
      if (strobe.setUnf) unfQ <= 1'b1;
    end
  end

  assign pc           = pcQ;
  assign activeMask   = maskQ;
  assign overflowErr  = ovfQ;
  assign underflowErr = unfQ;

  // R9: a running warp keeps at least one lane unless lanes exit
  p_mask_alive_r9: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ != '0 && !exitNow) |=> (maskQ != '0));

  // R9: a finished warp stays finished with a frozen PC
  p_finished_stays_r9: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |=> (maskQ == '0 && $stable(pcQ)));

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    ovfQ |=> ovfQ);

  p_no_overrun_r10: assert property (@(posedge clk) disable iff (!rstN)
    depthQ <= CNT_W'(DEPTH));

  p_unf_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    unfQ |=> unfQ);

  // R5: a split keeps only lanes that were already active, and some of them
  p_taken_subset_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.maskSel == MK_TAKEN) |=>
      ((maskQ & ~$past(maskQ)) == '0 && maskQ != '0));

  p_push_grows_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doPush |=> (depthQ == $past(depthQ) + CNT_W'(1)));

  p_push_pop_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.doPush, strobe.doPop}));

endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
  import simt_pkg::*;
#(
  parameter int LANES    = 32,
  parameter int PC_W     = 32,
  parameter int DEPTH    = 16,
  parameter int PC_STEP  = 8,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [2:0]       opKind,
  input  logic [PC_W-1:0]  opTarget,
  input  logic [LANES-1:0] predMask,
  output logic [PC_W-1:0]  pc,
  output logic [PC_W-1:0]  nextPc,
  output logic [LANES-1:0] activeMask,
  output logic [LANES-1:0] nextMask,
  output logic             overflowErr,
  output logic             underflowErr
);

  strobe_t strobe;
  logic running, effNone, effAll, remainNone, stackFull, foundValid;
  logic exitNow;

  assign exitNow = opValid && (opKind == OP_EXIT);

  simt_reconv_ctrl uCtrl (
    .opValid    (opValid),
    .opKind     (opKind),
    .running    (running),
    .effNone    (effNone),
    .effAll     (effAll),
    .remainNone (remainNone),
    .stackFull  (stackFull),
    .foundValid (foundValid),
    .strobe     (strobe)
  );

  simt_reconv_dpath #(
    .LANES    (LANES),
    .PC_W     (PC_W),
    .DEPTH    (DEPTH),
    .PC_STEP  (PC_STEP),
    .RESET_PC (RESET_PC)
  ) uDpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .exitNow      (exitNow),
    .opTarget     (opTarget),
    .predMask     (predMask),
    .pc           (pc),
    .nextPc       (nextPc),
    .activeMask   (activeMask),
    .nextMask     (nextMask),
    .overflowErr  (overflowErr),
    .underflowErr (underflowErr),
    .running      (running),
    .effNone      (effNone),
    .effAll       (effAll),
    .remainNone   (remainNone),
    .stackFull    (stackFull),
    .foundValid   (foundValid)
  );

endmodule

// File: tb/tb_simt_reconv_stack.sv
module tb_simt_reconv_stack;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opKind = 3'd0;
  logic [31:0] opTarget = '0;
  logic [31:0] predMask = '0;
  logic [31:0] pc, nextPc, activeMask, nextMask;
  logic        overflowErr, underflowErr;

  int testCnt = 0;
  int failCnt = 0;

  typedef struct {
    logic [31:0] pc;
    logic [31:0] mask;
    logic        ovf;
    logic        unf;
    string       tag;
  } exp_t;

  exp_t expQ[$];

  always #5 clk = ~clk;

  simt_reconv_stack dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind),
    .opTarget(opTarget), .predMask(predMask), .pc(pc), .nextPc(nextPc),
    .activeMask(activeMask), .nextMask(nextMask),
    .overflowErr(overflowErr), .underflowErr(underflowErr)
  );

  task automatic check(input bit ok, input string tag, input string what);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s", tag, what);
    end
  endtask

  // drive one operation, check the combinational answer, queue the registered one
  task automatic drive(input logic v, input logic [2:0] k, input logic [31:0] tgt,
                       input logic [31:0] pr, input logic [31:0] ePc,
                       input logic [31:0] eMask, input logic eOvf,
                       input logic eUnf, input string tag);
    exp_t it;
    @(negedge clk);
    opValid = v; opKind = k; opTarget = tgt; predMask = pr;
    #1;
    check(nextPc == ePc && nextMask == eMask, tag,
          $sformatf("next actual pc=%h mask=%h expected pc=%h mask=%h",
                    nextPc, nextMask, ePc, eMask));
    it.pc = ePc; it.mask = eMask; it.ovf = eOvf; it.unf = eUnf; it.tag = tag;
    expQ.push_back(it);
    @(posedge clk);
  endtask

  // monitor: compares the registered state after each edge
  always @(posedge clk) begin
    if (rstN) begin
      #1;
      if (expQ.size() > 0) begin
        exp_t it;
        it = expQ.pop_front();
        check(pc == it.pc && activeMask == it.mask &&
              overflowErr == it.ovf && underflowErr == it.unf, it.tag,
              $sformatf("actual pc=%h mask=%h ovf=%b unf=%b expected pc=%h mask=%h ovf=%b unf=%b",
                        pc, activeMask, overflowErr, underflowErr,
                        it.pc, it.mask, it.ovf, it.unf));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    testCnt++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pc == 32'h0 && activeMask == 32'hFFFF_FFFF && !overflowErr && !underflowErr,
          "R1", $sformatf("reset actual pc=%h mask=%h ovf=%b unf=%b expected pc=0 mask=ffffffff ovf=0 unf=0",
                          pc, activeMask, overflowErr, underflowErr));
    rstN = 1'b1;

    // R2: sequencing, stall, reserved codes
    drive(1, 3'd0, 0, 0, 32'h008, 32'hFFFF_FFFF, 0, 0, "R2");
    drive(0, 3'd0, 0, 0, 32'h008, 32'hFFFF_FFFF, 0, 0, "R2");
    drive(1, 3'd6, 0, 0, 32'h010, 32'hFFFF_FFFF, 0, 0, "R2");

    // R3/R5/R6: simple if/else divergence and rejoin
    drive(1, 3'd1, 32'h100, 0, 32'h018, 32'hFFFF_FFFF, 0, 0, "R3");
    drive(1, 3'd2, 32'h040, 32'h0000_FFFF, 32'h040, 32'h0000_FFFF, 0, 0, "R5");
    drive(1, 3'd0, 0, 0, 32'h048, 32'h0000_FFFF, 0, 0, "R2");
    drive(1, 3'd3, 0, 0, 32'h020, 32'hFFFF_0000, 0, 0, "R6");
    drive(1, 3'd3, 0, 0, 32'h100, 32'hFFFF_FFFF, 0, 0, "R6");

    // R4: uniform branches push nothing
    drive(1, 3'd1, 32'h200, 0, 32'h108, 32'hFFFF_FFFF, 0, 0, "R3");
    drive(1, 3'd2, 32'h300, 32'hFFFF_FFFF, 32'h300, 32'hFFFF_FFFF, 0, 0, "R4");
    drive(1, 3'd2, 32'h400, 32'h0, 32'h308, 32'hFFFF_FFFF, 0, 0, "R4");
    drive(1, 3'd3, 0, 0, 32'h200, 32'hFFFF_FFFF, 0, 0, "R4");

    // R11: pop of an empty stack
    drive(1, 3'd3, 0, 0, 32'h208, 32'hFFFF_FFFF, 0, 1, "R11");
    drive(1, 3'd0, 0, 0, 32'h210, 32'hFFFF_FFFF, 0, 1, "R11");

    // R7/R8/R9: nested divergence with lanes retiring
    drive(1, 3'd1, 32'h500, 0, 32'h218, 32'hFFFF_FFFF, 0, 1, "R3");
    drive(1, 3'd2, 32'h600, 32'h0000_00FF, 32'h600, 32'h0000_00FF, 0, 1, "R5");
    drive(1, 3'd1, 32'h700, 0, 32'h608, 32'h0000_00FF, 0, 1, "R3");
    drive(1, 3'd2, 32'h800, 32'h0000_000F, 32'h800, 32'h0000_000F, 0, 1, "R5");
    drive(1, 3'd4, 0, 32'h0000_0003, 32'h808, 32'h0000_000C, 0, 1, "R8");
    drive(1, 3'd4, 0, 32'h0000_00FF, 32'h610, 32'h0000_00F0, 0, 1, "R9");
    drive(1, 3'd4, 0, 32'hFFFF_FFFF, 32'h220, 32'hFFFF_FF00, 0, 1, "R7");
    drive(1, 3'd3, 0, 0, 32'h500, 32'hFFFF_FF00, 0, 1, "R8");
    drive(1, 3'd0, 0, 0, 32'h508, 32'hFFFF_FF00, 0, 1, "R2");

    // R10: fill the stack, then overflow
    for (int i = 0; i < 16; i++)
      drive(1, 3'd1, 32'h1000, 0, 32'h510 + 32'(i) * 32'h8, 32'hFFFF_FF00, 0, 1, "R10");
    drive(1, 3'd1, 32'h1000, 0, 32'h590, 32'hFFFF_FF00, 1, 1, "R10");
    drive(1, 3'd2, 32'h900, 32'h0000_FF00, 32'h900, 32'h0000_FF00, 1, 1, "R10");
    drive(1, 3'd3, 0, 0, 32'h1000, 32'hFFFF_FF00, 1, 1, "R10");

    // R9: all lanes exit with only empty entries left
    drive(1, 3'd4, 0, 32'hFFFF_FFFF, 32'h1000, 32'h0, 1, 1, "R9");
    drive(1, 3'd0, 0, 0, 32'h1000, 32'h0, 1, 1, "R9");
    drive(1, 3'd1, 32'h2000, 0, 32'h1000, 32'h0, 1, 1, "R9");

    @(negedge clk);
    opValid = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check(expQ.size() == 0, "R6", $sformatf("pending actual=%0d expected=0", expQ.size()));
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule